// File: doc/BRIEF.md
# Device Interrupt Aggregator

This block gathers interrupt requests from many device sources into one request toward a host link. Sources are arranged in two banks of 32, and each source has three pieces of state: a trigger mode (level or edge), a pending indication and an enable. Software reaches the block through a small 32-bit register port. It chooses each source's trigger mode and turns enables on and off through two write-only ports, one that sets bits and one that clears them. The enable state itself can only be read. The pending view is read-only. A software interrupt register allows software to raise a source itself and to acknowledge edge-latched events.

The block drives a level `irq_out` while any source is both pending and enabled. It also drives a one-cycle `msg_pulse` each time that condition starts, which a downstream message generator turns into a host-link message. Each bit position in a bank stands for one fixed device. The top bit of each bank is kept for the software interrupt source.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every enable, mode bit, software bit and edge latch is zero, so reads at 0x120+4b, 0x140+4b and 0x1A0+4b return 0, and `irq_out` and `msg_pulse` are low.
- R2: A write to 0x160+4b sets the enables of bank b where the data has ones. A write to 0x180+4b clears them where the data has ones. Zero data bits leave enables unchanged. The enable state reads at 0x140+4b, one cycle after the write.
- R3: When a source's mode bit (0x120+4b, 0 = level) is 0, its pending bit at 0x100+4b equals its request input in the same cycle, ORed with its software bit.
- R4: When a source's mode bit is 1 (edge), a rising request latches its pending bit from the next cycle on, and it stays latched after the request falls. Writing a one to that bit of 0x1A0+4b clears it. Writing a zero does not.
- R5: The pending registers (0x100+4b) and the enable status registers (0x140+4b) ignore writes.
- R6: For level-mode sources, the software register at 0x1A0+4b can be written and read back. A set bit makes that source pending. Bits of edge-mode sources read back as 0.
- R7: Writing 0 to an edge source's mode bit clears its edge latch, so a later return to edge mode starts with the source not pending.
- R8: Addresses of bank indices 2 and above, and any address outside 0x100 to 0x1BF, read as zero. Writes to them change no state.
- R9: `irq_out` is high one cycle after any source in either bank is both pending and enabled, and low one cycle after no such source remains. `msg_pulse` is high for exactly the first cycle of each rise of `irq_out`.
- R10: If a rising request on an edge source and an acknowledge of that same bit fall in the same cycle, the source stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| dev_req | input | 64 | Device request inputs, bank 1 in the upper 32 bits |
| irq_out | output | 1 | Registered request: some source pending and enabled |
| msg_pulse | output | 1 | One-cycle pulse when `irq_out` rises |

## Verification
The edge detector and the software acknowledge both update the same edge latch, and they can land in the same clock. To provoke this, the bench latches an edge source and lets its request fall. It then raises the request again in the very cycle that software writes the acknowledge bit. The source is judged correct if it still reads as pending afterwards, because the new event must not be lost. The bench also reads the pending view combinationally while requests change, and it times `irq_out` and `msg_pulse` against the cycle in which an enable write takes effect.

// File: rtl/irq_agg_pkg.sv
// Shared constants and types for the device interrupt aggregator.
// The register window starts at 0x100. Each register group is 0x20 bytes
// wide, and within a group the bank index selects a word.
package irq_agg_pkg;

    localparam logic [2:0] GRP_PEND = 3'd0;  // 0x100: pending view, read-only
    localparam logic [2:0] GRP_MODE = 3'd1;  // 0x120: trigger mode, 1 = edge
    localparam logic [2:0] GRP_EN   = 3'd2;  // 0x140: enable status, read-only
    localparam logic [2:0] GRP_SET  = 3'd3;  // 0x160: enable set, write-only
    localparam logic [2:0] GRP_CLR  = 3'd4;  // 0x180: enable clear, write-only
    localparam logic [2:0] GRP_SW   = 3'd5;  // 0x1A0: software / acknowledge

    // Per-bank write strobes produced by the address decoder
    typedef struct packed {
        logic mode_we;
        logic set_we;
        logic clr_we;
        logic sw_we;
    } bank_wr_t;

endpackage

// File: rtl/irq_bank.sv
// One bank of interrupt sources.
// For each source it holds a trigger mode, an enable, a software bit, an
// edge latch and a delayed copy of the request for edge detection.
// Assumes that requests are synchronous to clk. The write strobes come from
// the decoder and are never active for two functions in the same cycle.
module irq_bank
    import irq_agg_pkg::*;
#(
    parameter int SRC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bank_wr_t         wr,
    input  logic [SRC_W-1:0] wdata,
    input  logic [SRC_W-1:0] req,
    output logic [SRC_W-1:0] mode_q,
    output logic [SRC_W-1:0] en_q,
    output logic [SRC_W-1:0] sw_rd,
    output logic [SRC_W-1:0] pend
);

    logic [SRC_W-1:0] req_d;
    logic [SRC_W-1:0] edge_q;
    logic [SRC_W-1:0] sw_q;
    logic [SRC_W-1:0] rise;
    logic [SRC_W-1:0] ack;
    logic [SRC_W-1:0] edge_nxt;

    // Edge events, and acknowledges aimed at edge-mode sources
    always_comb begin
        rise = req & ~req_d;
        ack  = wr.sw_we ? (wdata & mode_q) : '0;
    end

    // Next edge latch: a new event wins over an acknowledge, re-arm clears
    always_comb begin
        edge_nxt = (edge_q & ~ack) | (rise & mode_q);
        if (wr.mode_we) begin
            edge_nxt = edge_nxt & wdata;
        end
    end

    // Source state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_d  <= '0;
            edge_q <= '0;
            mode_q <= '0;
            en_q   <= '0;
            sw_q   <= '0;
        end else begin
            req_d  <= req;
            edge_q <= edge_nxt;
            if (wr.mode_we) begin
                mode_q <= wdata;
            end
            if (wr.set_we) begin
                en_q <= en_q | wdata;
            end else if (wr.clr_we) begin
                en_q <= en_q & ~wdata;
            end
            if (wr.sw_we) begin
                sw_q <= wdata & ~mode_q;
            end
        end
    end

    // Pending view: edge sources show the latch, level sources the request or sw bit
    always_comb begin
        sw_rd = sw_q & ~mode_q;
        pend  = (mode_q & edge_q) | (~mode_q & (req | sw_q));
    end

endmodule

// File: rtl/irq_reg_decode.sv
// Address decoder and read multiplexer for the aggregator's register window.
// Valid addresses are word-aligned with addr[ADDR_W-1:8] equal to 1.
// addr[7:5] selects the group and addr[4:2] the bank. Bank indices at or
// above NUM_BANKS, and any other address, read as zero and decode to no write.
module irq_reg_decode
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [NUM_BANKS*SRC_W-1:0]    pend_all,
    input  logic [NUM_BANKS*SRC_W-1:0]    mode_all,
    input  logic [NUM_BANKS*SRC_W-1:0]    en_all,
    input  logic [NUM_BANKS*SRC_W-1:0]    sw_all,
    output bank_wr_t [NUM_BANKS-1:0]      wr_strb,
    output logic [SRC_W-1:0]              reg_rdata
);

    localparam int HI_W = ADDR_W - 8;

    logic       in_win;
    logic [2:0] grp;
    logic [2:0] bidx;

    // Split the address into window hit, group and bank index
    always_comb begin
        in_win = (reg_addr[ADDR_W-1:8] == HI_W'(1)) && (reg_addr[1:0] == 2'b00);
        grp    = reg_addr[7:5];
        bidx   = reg_addr[4:2];
    end

    // Select read data and per-bank write strobes
    always_comb begin
        reg_rdata = '0;
        wr_strb   = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (in_win && (int'(bidx) == b)) begin
                case (grp)
                    GRP_PEND: reg_rdata = pend_all[b*SRC_W +: SRC_W];
                    GRP_MODE: begin
                        reg_rdata          = mode_all[b*SRC_W +: SRC_W];
                        wr_strb[b].mode_we = reg_wr;
                    end
                    GRP_EN:   reg_rdata = en_all[b*SRC_W +: SRC_W];
                    GRP_SET:  wr_strb[b].set_we = reg_wr;
                    GRP_CLR:  wr_strb[b].clr_we = reg_wr;
                    GRP_SW: begin
                        reg_rdata        = sw_all[b*SRC_W +: SRC_W];
                        wr_strb[b].sw_we = reg_wr;
                    end
                    default: reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
// Top level of the device interrupt aggregator.
// It instantiates one irq_bank per bank and a shared register decoder. It
// registers the OR of pending and enabled over all banks into irq_out, and
// pulses msg_pulse in the first cycle of each rise of irq_out.
// Assumes dev_req is synchronous to clk.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [SRC_W-1:0]           reg_wdata,
    output logic [SRC_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*SRC_W-1:0] dev_req,
    output logic                       irq_out,
    output logic                       msg_pulse
);

    localparam int TOT_W = NUM_BANKS * SRC_W;

    bank_wr_t [NUM_BANKS-1:0] wr_strb;
    logic [TOT_W-1:0]         pend_all;
    logic [TOT_W-1:0]         mode_all;
    logic [TOT_W-1:0]         en_all;
    logic [TOT_W-1:0]         sw_all;
    logic                     any_active;

    irq_reg_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SRC_W     (SRC_W),
        .ADDR_W    (ADDR_W)
    ) u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .pend_all  (pend_all),
        .mode_all  (mode_all),
        .en_all    (en_all),
        .sw_all    (sw_all),
        .wr_strb   (wr_strb),
        .reg_rdata (reg_rdata)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        irq_bank #(
            .SRC_W (SRC_W)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_strb[g]),
            .wdata  (reg_wdata),
            .req    (dev_req[g*SRC_W +: SRC_W]),
            .mode_q (mode_all[g*SRC_W +: SRC_W]),
            .en_q   (en_all[g*SRC_W +: SRC_W]),
            .sw_rd  (sw_all[g*SRC_W +: SRC_W]),
            .pend   (pend_all[g*SRC_W +: SRC_W])
        );
    end

    // Any source pending and enabled in any bank
    always_comb begin
        any_active = |(pend_all & en_all);
    end

    // Registered request level and its rise pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_out   <= 1'b0;
            msg_pulse <= 1'b0;
        end else begin
            irq_out   <= any_active;
            msg_pulse <= any_active & ~irq_out;
        end
    end

endmodule

// File: rtl/irq_aggregator_checker.sv
// Assertion checker for irq_aggregator, attached with bind.
// It watches the register port, the combined enable and pending vectors and
// the request outputs.
module irq_aggregator_checker #(
    parameter int NUM_BANKS = 2,
    parameter int SRC_W     = 32,
    parameter int ADDR_W    = 12
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       reg_wr,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic [SRC_W-1:0]           reg_wdata,
    input logic [NUM_BANKS*SRC_W-1:0] en_all,
    input logic [NUM_BANKS*SRC_W-1:0] pend_all,
    input logic                       irq_out,
    input logic                       msg_pulse
);

    localparam logic [ADDR_W-1:0] A_SET0 = ADDR_W'(12'h160);
    localparam logic [ADDR_W-1:0] A_CLR0 = ADDR_W'(12'h180);

    // R1: the first cycle out of reset has no enables and no request
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (en_all == '0 && !irq_out && !msg_pulse));

    // R2: a set write leaves every written one enabled
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET0) |=>
            ((en_all[SRC_W-1:0] & $past(reg_wdata)) == $past(reg_wdata)));

    // R2: a clear write leaves every written one disabled
    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR0) |=>
            ((en_all[SRC_W-1:0] & $past(reg_wdata)) == '0));

    // R9: irq_out follows pending-and-enabled with one cycle of delay
    assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_all & en_all)) |=> irq_out);

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_all & en_all)) |=> !irq_out);

    // R9: the message pulse only comes with irq_out and lasts one cycle
    assert_pulse_with_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |-> irq_out);

    assert_pulse_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |=> !msg_pulse);

endmodule

bind irq_aggregator irq_aggregator_checker #(
    .NUM_BANKS (NUM_BANKS),
    .SRC_W     (SRC_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .en_all    (en_all),
    .pend_all  (pend_all),
    .irq_out   (irq_out),
    .msg_pulse (msg_pulse)
);

// File: tb/irq_aggregator_test.sv
// Directed bench for irq_aggregator: one task per scenario, each checking itself.
module irq_aggregator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] dev_req = '0;
    logic        irq_out;
    logic        msg_pulse;

    int checks = 0;
    int errors = 0;

    irq_aggregator uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_req   (dev_req),
        .irq_out   (irq_out),
        .msg_pulse (msg_pulse)
    );

    always #2 clk = ~clk;  // 250 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_wr = 1'b0; dev_req = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(12'h120, v); check("R1 mode", v, 32'h0);
        rd(12'h144, v); check("R1 enable", v, 32'h0);
        rd(12'h1A0, v); check("R1 sw", v, 32'h0);
        check("R1 irq_out", {31'h0, irq_out}, 32'h0);
        check("R1 msg_pulse", {31'h0, msg_pulse}, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        do_reset();
        wr(12'h160, 32'h0000_F00F);
        rd(12'h140, v); check("R2 set", v, 32'h0000_F00F);
        wr(12'h160, 32'h8000_0000);
        rd(12'h140, v); check("R2 set keeps", v, 32'h8000_F00F);
        wr(12'h180, 32'h0000_100F);
        rd(12'h140, v); check("R2 clear", v, 32'h8000_E000);
        rd(12'h144, v); check("R2 other bank", v, 32'h0);
        wr(12'h164, 32'h0010_0000);
        rd(12'h144, v); check("R2 bank1 set", v, 32'h0010_0000);
    endtask

    task automatic t_level();
        logic [31:0] v;
        do_reset();
        @(negedge clk); dev_req[12] = 1'b1;
        rd(12'h100, v); check("R3 level high", v, 32'h0000_1000);
        @(negedge clk); dev_req[12] = 1'b0;
        rd(12'h100, v); check("R3 level low", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        do_reset();
        wr(12'h124, 32'h0000_0100);
        @(negedge clk); dev_req[40] = 1'b1;
        @(negedge clk); dev_req[40] = 1'b0;
        rd(12'h104, v); check("R4 edge latched", v, 32'h0000_0100);
        @(negedge clk); @(negedge clk);
        rd(12'h104, v); check("R4 edge holds", v, 32'h0000_0100);
        wr(12'h1A4, 32'h0);
        rd(12'h104, v); check("R4 zero ack ignored", v, 32'h0000_0100);
        wr(12'h1A4, 32'h0000_0100);
        rd(12'h104, v); check("R4 ack clears", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        do_reset();
        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, v); check("R5 pending write ignored", v, 32'h0);
        wr(12'h140, 32'hFFFF_FFFF);
        rd(12'h140, v); check("R5 enable status write ignored", v, 32'h0);
    endtask

    task automatic t_sw();
        logic [31:0] v;
        do_reset();
        wr(12'h120, 32'h0000_0001);
        wr(12'h1A0, 32'h8000_0001);
        rd(12'h1A0, v); check("R6 sw readback", v, 32'h8000_0000);
        rd(12'h100, v); check("R6 sw pending", v, 32'h8000_0000);
        wr(12'h1A0, 32'h0);
        rd(12'h100, v); check("R6 sw cleared", v, 32'h0);
    endtask

    task automatic t_rearm();
        logic [31:0] v;
        do_reset();
        wr(12'h120, 32'h0010_0000);
        @(negedge clk); dev_req[20] = 1'b1;
        @(negedge clk); dev_req[20] = 1'b0;
        rd(12'h100, v); check("R7 latched first", v, 32'h0010_0000);
        wr(12'h120, 32'h0);
        wr(12'h120, 32'h0010_0000);
        rd(12'h100, v); check("R7 rearm clears", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        do_reset();
        dev_req = 64'hFFFF_FFFF_FFFF_FFFF;
        wr(12'h128, 32'hFFFF_FFFF);
        wr(12'h168, 32'hFFFF_FFFF);
        rd(12'h108, v); check("R8 bank2 pending", v, 32'h0);
        rd(12'h128, v); check("R8 bank2 mode", v, 32'h0);
        rd(12'h000, v); check("R8 low address", v, 32'h0);
        rd(12'h1C0, v); check("R8 past window", v, 32'h0);
        rd(12'h140, v); check("R8 bank0 enable untouched", v, 32'h0);
        rd(12'h124, v); check("R8 bank1 mode untouched", v, 32'h0);
        dev_req = '0;
    endtask

    task automatic t_output();
        do_reset();
        @(negedge clk); dev_req[6] = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R9 disabled source quiet", {31'h0, irq_out}, 32'h0);
        dev_req[6] = 1'b0;
        wr(12'h160, 32'h0000_0020);
        @(negedge clk); dev_req[5] = 1'b1;
        check("R9 no early irq", {31'h0, irq_out}, 32'h0);
        @(negedge clk);
        check("R9 irq rises", {31'h0, irq_out}, 32'h1);
        check("R9 pulse", {31'h0, msg_pulse}, 32'h1);
        @(negedge clk);
        check("R9 pulse one cycle", {31'h0, msg_pulse}, 32'h0);
        check("R9 irq holds", {31'h0, irq_out}, 32'h1);
        dev_req[5] = 1'b0;
        @(negedge clk);
        check("R9 irq falls", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        do_reset();
        wr(12'h120, 32'h0000_0004);
        @(negedge clk); dev_req[2] = 1'b1;
        @(negedge clk); dev_req[2] = 1'b0;
        @(negedge clk);
        rd(12'h100, v); check("R10 precondition", v, 32'h0000_0004);
        @(negedge clk);
        dev_req[2] = 1'b1;
        reg_wr = 1'b1; reg_addr = 12'h1A0; reg_wdata = 32'h0000_0004;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(12'h100, v); check("R10 new edge beats ack", v, 32'h0000_0004);
        dev_req[2] = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_readonly();
        t_sw();
        t_rearm();
        t_unmapped();
        t_output();
        t_collision();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule